// File: doc/BRIEF.md
# Serial frame receiver with CRC-8 integrity check

This block is the serial front end of a slave device. It oversamples the SPI clock, chip select and data lines on the system clock. It collects one frame per chip-select window and turns each accepted frame into a 24-bit write word on a valid/ready stream. A control input selects between plain 24-bit frames and protected 32-bit frames. In a protected frame the last 8 bits carry a CRC-8 over the 24 data bits.

A protected frame is accepted only when the CRC register, run over all 32 received bits, ends at zero. A frame that fails is dropped, and it sets a sticky error flag. That flag, together with an external fault input, drives an active-low alarm line that can be wire-ANDed with other devices. For readback, a 24-bit word is handed in on a second valid/ready stream and shifted out on SDO during the next frame, followed by its own CRC-8.

Stream rules: the write stream holds `wr_valid` and `wr_data` steady until `wr_ready` is seen high. A frame that completes while a word is still pending is discarded. The readback stream is accepted only while chip select is idle.

Top module: `spi_crc_frame_chk`

## Requirements
- R1: CRC-8 uses generator 0x07 (x^8+x^2+x+1), starts at 0x00, takes bits MSB first and has no final XOR. With `crc_en`=1, a frame of exactly 32 SCLK rising edges is written as its first 24 bits when the remainder over all 32 bits is zero.
- R2: With `crc_en`=0, a frame of exactly 24 SCLK rising edges produces `wr_data` equal to those bits, the first one received landing in bit 23.
- R3: With `crc_en`=0, a frame of exactly 32 edges is accepted, and only its last 24 bits received form `wr_data`.
- R4: A frame with any other edge count (for `crc_en`=1, anything but 32, including 24) produces no write and does not set `crc_err`.
- R5: With `crc_en`=1, a 32-edge frame with a non-zero remainder produces no write and sets `crc_err`. `crc_err` stays 1 through later good frames.
- R6: `alarm_n` is 0 whenever `crc_err` or `fault_in` is 1, and 1 otherwise.
- R7: `crc_err` returns to 0 on reset, while `crc_en` is 0, and while `pwr_dn` is 1.
- R8: A committed word keeps `wr_valid`=1 and `wr_data` stable until a cycle with `wr_ready`=1. A frame that ends while a word is pending is dropped.
- R9: `rd_ready` is 1 only while chip select is idle. After a `rd_valid`/`rd_ready` handshake, the next frame shifts out on `sdo` the 24 data bits MSB first and then their CRC-8 (R1 rule), each bit changing after an SCLK falling edge. `sdo` is 0 outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | 1 selects 32-bit protected frames |
| pwr_dn | input | 1 | Power-down, clears the error flag |
| fault_in | input | 1 | Other fault source merged into the alarm |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial readback data |
| wr_valid | output | 1 | Write word available |
| wr_ready | input | 1 | Consumer takes the write word |
| wr_data | output | 24 | Accepted frame payload |
| rd_valid | input | 1 | Readback word offered |
| rd_ready | output | 1 | Readback word taken (idle chip select only) |
| rd_data | input | 24 | Readback word |
| crc_err | output | 1 | Sticky CRC error flag |
| alarm_n | output | 1 | Active-low alarm |

## Verification
The hardest case to reach from the ports is a protected frame of exactly the right length whose remainder is non-zero for every possible single corrupted bit, including flips inside the CRC byte itself. The bench builds one correct frame, then sends it 32 more times, flipping one bit position each time, and clears the flag between attempts. A second hard case is a frame finishing while the write stream is stalled. The bench holds `wr_ready` low across two complete frames and confirms that only the first word appears once the stall ends.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  // one serial CRC step, MSB-first, no reflection
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_active,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);
  localparam int NCH = 3;  // 0: sclk, 1: cs_n, 2: mosi
  logic [NCH-1:0] raw, synced;
  logic [NCH-1:0] prev;

  assign raw = {mosi, cs_n, sclk};

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam logic IDLE = (g == 1) ? 1'b1 : 1'b0;
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE}};
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 3'b010;
    else        prev <= synced;
  end

  assign sclk_rise = synced[0] & ~prev[0];
  assign sclk_fall = ~synced[0] & prev[0];
  assign cs_active = ~synced[1];
  assign cs_start  = ~synced[1] & prev[1];
  assign cs_end    = synced[1] & ~prev[1];
  assign mosi_s    = synced[2];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_crc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_en,
  input  logic              sclk_rise,
  input  logic              cs_active,
  input  logic              cs_start,
  input  logic              cs_end,
  input  logic              mosi_s,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_bad
);
  localparam int FRAME_W = DATA_W + CRC_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_LONG  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SHORT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic [CRC_W-1:0]   crc;
  logic len_long, len_short, frame_good, pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      crc <= '0;
    end else if (cs_start) begin
      cnt <= '0;
      crc <= '0;
    end else if (cs_active && sclk_rise) begin
      sh  <= {sh[FRAME_W-2:0], mosi_s};
      crc <= crc_step(crc, mosi_s);
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign len_long   = (cnt == CNT_LONG);
  assign len_short  = (cnt == CNT_SHORT);
  assign frame_good = cs_end && (crc_en ? (len_long && crc == '0) : (len_long || len_short));
  assign frame_bad  = cs_end && crc_en && len_long && (crc != '0);
  assign pending    = wr_valid && !wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (frame_good && !pending) begin
      wr_valid <= 1'b1;
      wr_data  <= crc_en ? sh[FRAME_W-1:CRC_W] : sh[DATA_W-1:0];
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assert_bad_frame_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> !$rose(wr_valid));
  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
endmodule

// File: rtl/spi_err_status.sv
module spi_err_status (
  input  logic clk,
  input  logic rst_n,
  input  logic crc_en,
  input  logic pwr_dn,
  input  logic fault_in,
  input  logic frame_bad,
  output logic crc_err,
  output logic alarm_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  crc_err <= 1'b0;
    else if (!crc_en || pwr_dn)  crc_err <= 1'b0;
    else if (frame_bad)          crc_err <= 1'b1;
  end

  assign alarm_n = ~(crc_err | fault_in);
endmodule

// File: rtl/spi_readback_tx.sv
module spi_readback_tx
  import spi_crc_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              sclk_fall,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              sdo
);
  localparam int FRAME_W = DATA_W + CRC_W;

  logic [FRAME_W-1:0] tx_sh;
  logic [CRC_W-1:0]   rd_crc;

  always_comb begin
    rd_crc = '0;
    for (int i = DATA_W - 1; i >= 0; i--) rd_crc = crc_step(rd_crc, rd_data[i]);
  end

  assign rd_ready = !cs_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tx_sh <= '0;
    else if (rd_valid && rd_ready)   tx_sh <= {rd_data, rd_crc};
    else if (cs_active && sclk_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
  end

  assign sdo = cs_active & tx_sh[FRAME_W-1];

  assert_sdo_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && sclk_fall) |=> (!cs_active || sdo == $past(tx_sh[FRAME_W-2])));
endmodule

// File: rtl/spi_crc_frame_chk.sv
module spi_crc_frame_chk
  import spi_crc_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_en,
  input  logic              pwr_dn,
  input  logic              fault_in,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              sdo,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic              crc_err,
  output logic              alarm_n
);
  logic sclk_rise, sclk_fall, cs_active, cs_start, cs_end, mosi_s, frame_bad;

  spi_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk, .rst_n, .sclk, .cs_n, .mosi,
    .sclk_rise, .sclk_fall, .cs_active, .cs_start, .cs_end, .mosi_s
  );

  spi_frame_rx #(.DATA_W(DATA_W)) rx_i (
    .clk, .rst_n, .crc_en, .sclk_rise, .cs_active, .cs_start, .cs_end, .mosi_s,
    .wr_ready, .wr_valid, .wr_data, .frame_bad
  );

  spi_err_status stat_i (
    .clk, .rst_n, .crc_en, .pwr_dn, .fault_in, .frame_bad, .crc_err, .alarm_n
  );

  spi_readback_tx #(.DATA_W(DATA_W)) tx_i (
    .clk, .rst_n, .cs_active, .sclk_fall, .rd_valid, .rd_data, .rd_ready, .sdo
  );

  assert_fail_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_bad && crc_en && !pwr_dn) |=> crc_err);
  assert_err_drives_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err || fault_in) |-> !alarm_n);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_en || pwr_dn) |=> !crc_err);
endmodule

// File: tb/spi_crc_frame_chk_tb.sv
module spi_crc_frame_chk_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, crc_en = 0, pwr_dn = 0, fault_in = 0;
  logic sclk = 0, cs_n = 1, mosi = 0, wr_ready = 1, rd_valid = 0;
  logic [23:0] rd_data = '0;
  logic sdo, wr_valid, rd_ready, crc_err, alarm_n;
  logic [23:0] wr_data;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [23:0] last_wr = '0;
  logic [31:0] sdo_bits;
  logic rd_ready_mid;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_crc_frame_chk dut_i (
    .clk, .rst_n, .crc_en, .pwr_dn, .fault_in, .sclk, .cs_n, .mosi, .sdo,
    .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data, .crc_err, .alarm_n
  );

  always @(posedge clk) if (wr_valid && wr_ready) begin wr_cnt++; last_wr = wr_data; end

  // long division by 0x107 over data followed by eight zero bits
  function automatic logic [7:0] bcrc(input logic [23:0] d);
    logic [31:0] v;
    v = {d, 8'h00};
    for (int i = 31; i >= 8; i--) if (v[i]) v = v ^ (32'h107 << (i - 8));
    return v[7:0];
  endfunction

  typedef struct packed {
    logic en; logic [5:0] nbits; logic [31:0] frame;
    logic exp_wr; logic [23:0] exp_data; logic exp_err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 6'd24, 32'h0012_3456, 1'b1, 24'h123456, 1'b0},                   // R2
    '{1'b0, 6'd32, 32'hFFAB_CDEF, 1'b1, 24'hABCDEF, 1'b0},                   // R3
    '{1'b0, 6'd20, 32'h000F_FFFF, 1'b0, 24'h0,      1'b0},                   // R4
    '{1'b1, 6'd32, {24'h00F00D, bcrc(24'h00F00D)}, 1'b1, 24'h00F00D, 1'b0},  // R1
    '{1'b1, 6'd32, {24'hFFFFFF, bcrc(24'hFFFFFF)}, 1'b1, 24'hFFFFFF, 1'b0},  // R1
    '{1'b1, 6'd24, 32'h0012_3456, 1'b0, 24'h0,      1'b0},                   // R4
    '{1'b1, 6'd31, 32'h1234_5678, 1'b0, 24'h0,      1'b0},                   // R4
    '{1'b1, 6'd32, {24'h123456, bcrc(24'h123456) ^ 8'h01}, 1'b0, 24'h0, 1'b1} // R5
  };
  localparam string VTAG [8] = '{"R2", "R3", "R4", "R1", "R1", "R4", "R4", "R5"};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] f, input int n);
    cs_n = 0;
    clks(HALF);
    sdo_bits = '0;
    for (int i = 0; i < n; i++) begin
      mosi = f[n-1-i];
      if (i == 0) rd_ready_mid = rd_ready;
      clks(HALF);
      sdo_bits = {sdo_bits[30:0], sdo};
      sclk = 1;
      clks(HALF);
      sclk = 0;
    end
    clks(HALF);
    cs_n = 1;
    clks(12);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [31:0] good;
    clks(3);
    check(wr_valid == 0 && crc_err == 0, "R7", "reset wr_valid/crc_err", {wr_valid, crc_err}, 0);
    check(alarm_n == 1 && sdo == 0, "R6", "reset alarm_n/sdo", {alarm_n, sdo}, 2);
    rst_n = 1;
    clks(3);
    check(rd_ready == 1, "R9", "idle rd_ready", rd_ready, 1);

    // table of vectors
    foreach (VECS[k]) begin
      crc_en = VECS[k].en;
      clks(3);
      c0 = wr_cnt;
      send_frame(VECS[k].frame, int'(VECS[k].nbits));
      check((wr_cnt - c0) == int'(VECS[k].exp_wr), VTAG[k], "write count", wr_cnt - c0, VECS[k].exp_wr);
      if (VECS[k].exp_wr)
        check(last_wr == VECS[k].exp_data, VTAG[k], "write data", last_wr, VECS[k].exp_data);
      check(crc_err == VECS[k].exp_err, VTAG[k], "crc_err", crc_err, VECS[k].exp_err);
    end

    // flag set: alarm, stickiness
    check(alarm_n == 0, "R6", "alarm with crc_err", alarm_n, 0);
    send_frame({24'h00F00D, bcrc(24'h00F00D)}, 32);
    check(crc_err == 1, "R5", "sticky after good frame", crc_err, 1);
    pwr_dn = 1; clks(2); pwr_dn = 0; clks(2);
    check(crc_err == 0, "R7", "pwr_dn clears", crc_err, 0);
    check(alarm_n == 1, "R6", "alarm released", alarm_n, 1);
    fault_in = 1; clks(1);
    check(alarm_n == 0, "R6", "alarm from fault_in", alarm_n, 0);
    fault_in = 0; clks(1);

    send_frame(32'h1, 32);
    check(crc_err == 1, "R5", "bad frame sets flag", crc_err, 1);
    crc_en = 0; clks(3);
    check(crc_err == 0, "R7", "crc_en low clears", crc_err, 0);
    crc_en = 1; clks(3);
    send_frame(32'h1, 32);
    rst_n = 0; clks(2);
    check(crc_err == 0, "R7", "reset clears", crc_err, 0);
    rst_n = 1; clks(3);

    // every single-bit corruption of a good protected frame
    good = {24'h5A3C96, bcrc(24'h5A3C96)};
    for (int b = 0; b < 32; b++) begin
      c0 = wr_cnt;
      send_frame(good ^ (32'h1 << b), 32);
      check(wr_cnt == c0 && crc_err == 1, "R5", $sformatf("flip bit %0d", b),
            {wr_cnt[15:0] - c0[15:0], 15'd0, crc_err}, 32'h1);
      pwr_dn = 1; clks(2); pwr_dn = 0; clks(2);
    end

    // stalled write stream
    wr_ready = 0;
    c0 = wr_cnt;
    send_frame({24'hC0FFEE, bcrc(24'hC0FFEE)}, 32);
    check(wr_valid == 1 && wr_data == 24'hC0FFEE, "R8", "held word", wr_data, 24'hC0FFEE);
    send_frame({24'h111111, bcrc(24'h111111)}, 32);
    check(wr_data == 24'hC0FFEE, "R8", "second frame dropped", wr_data, 24'hC0FFEE);
    wr_ready = 1; clks(3);
    check(wr_cnt - c0 == 1 && last_wr == 24'hC0FFEE && wr_valid == 0, "R8", "single transfer",
          last_wr, 24'hC0FFEE);

    // readback
    rd_data = 24'h3C5A81; rd_valid = 1;
    clks(1);
    rd_valid = 0;
    send_frame(32'h0, 32);
    check(rd_ready_mid == 0, "R9", "rd_ready during frame", rd_ready_mid, 0);
    check(sdo_bits == {24'h3C5A81, bcrc(24'h3C5A81)}, "R9", "sdo frame", sdo_bits,
          {24'h3C5A81, bcrc(24'h3C5A81)});
    rd_data = 24'hFFFFFF; rd_valid = 1;
    clks(1);
    rd_valid = 0;
    send_frame(32'h0, 32);
    check(sdo_bits == {24'hFFFFFF, bcrc(24'hFFFFFF)}, "R9", "sdo frame ones", sdo_bits,
          {24'hFFFFFF, bcrc(24'hFFFFFF)});
    check(sdo == 0, "R9", "sdo idle", sdo, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule